// File: doc/BRIEF.md
# Setup Table and Configuration Dispatcher

This block manages configuration for an array of processing elements. It leaves reset and walks a list of metadata records held in configuration memory. From those records it builds a small table that gives, for each setup number, the place of that setup's code, its length and its signatures. Because the code address is read at run time and not fixed at design time, code can sit anywhere in memory.

Once the table is built, the block accepts requests for setups. For a known setup it reads each of the setup's signatures in turn. For each signature it streams every code word over a shared configuration bus. A signature is a row mask paired with a column mask. The per-element write enables are decoded from it, so only the selected loaders store the word into their 16-entry instruction memories. An unknown setup number gives an error pulse. A finished transfer gives a done pulse, which can drive the configuration-done input of a clock gating controller.

Top module: `cfgd_dispatcher`

## Requirements
- R1: After reset the block reads metadata starting at address META_BASE. The first word holds the record count. It accepts no request (`req_ready` low) until every record has been read.
- R2: A record occupies consecutive words in this order: setup number, code start address, code length, signature count, then that many signature words. The next record follows at once.
- R3: For an accepted request, word k of the code is read from address start+k of the record that names the setup. Its data appears on `cfg_bus_data` with `cfg_bus_idx` = k.
- R4: A setup with S signatures streams its whole code S times, once per signature, in record order.
- R5: A signature word carries the row mask in bits [PE_ROWS-1:0] and the column mask in bits [COL_MASK_LSB+PE_COLS-1:COL_MASK_LSB]. Element at column x, row y is bit y*PE_COLS+x of `pe_wr_en`. That bit is high only while `cfg_bus_valid` is high and both mask bits are set.
- R6: Within one signature pass, `cfg_bus_idx` starts at 0 and rises by one on each consecutive bus cycle.
- R7: A request for a setup number not in the table gives a single-cycle `req_err` pulse in the cycle after acceptance. It starts no transfer and gives no done pulse.
- R8: `cfg_done` pulses for one cycle, exactly one cycle after the last bus word of the transfer.
- R9: A code length above IMEM_DEPTH is cut to IMEM_DEPTH words.
- R10: When two records name the same setup number, the earlier record is used.
- R11: Records beyond the NUM_SETUPS table slots are skipped. Their setup numbers count as unknown.
- R12: `req_ready` is low, and `req_valid` is ignored, while the table is being built and while a transfer is running.
- R13: A setup with a signature count of zero gives a `cfg_done` pulse in the cycle after acceptance and no bus words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd_en | output | 1 | Configuration memory read strobe |
| mem_rd_addr | output | ADDR_W | Configuration memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| req_valid | input | 1 | Setup request |
| req_setup | input | SETUP_W | Requested setup number |
| req_ready | output | 1 | Block is idle and takes a request |
| req_err | output | 1 | Pulse: requested setup is not in the table |
| cfg_bus_valid | output | 1 | A code word is on the bus |
| cfg_bus_idx | output | $clog2(IMEM_DEPTH) | Instruction memory index of the word |
| cfg_bus_data | output | DATA_W | Code word |
| cfg_bus_row_mask | output | PE_ROWS | Row mask of the active signature |
| cfg_bus_col_mask | output | PE_COLS | Column mask of the active signature |
| pe_wr_en | output | PE_ROWS*PE_COLS | Per-element loader write enables |
| cfg_done | output | 1 | Pulse: transfer finished |

## Verification
The assertions assume three things about the inputs. Memory returns data exactly one cycle after a read strobe. The metadata is laid out as R2 states, with record count and signature counts within range. Nothing disturbs memory during a scan or a transfer. The bench meets these by using a memory model with a fixed one-cycle latency. It writes the whole metadata image before reset is released and never changes memory afterwards. It keeps requests within the rule that only `req_ready` cycles accept them. It also deliberately raises `req_valid` during table building and during a running transfer, to show such requests are dropped.

// File: rtl/cfgd_pkg.sv
// Shared definitions for the configuration dispatcher.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cfgd_pkg;

    // Sequencer phases: table build first, then request service.
    typedef enum logic [3:0] {
        ST_HDR,     // issue read of the record-count word
        ST_HDR_W,   // capture record count
        ST_FLD,     // issue read of one record field
        ST_FLD_W,   // capture that field
        ST_IDLE,    // wait for a request
        ST_SIG,     // issue read of one signature word
        ST_SIG_W,   // capture row/column masks
        ST_STR,     // issue one code read per cycle
        ST_DRAIN    // wait for the read pipeline to empty
    } seq_state_e;

    // Field order inside a metadata record (the scan depends on it).
    localparam logic [1:0] FLD_SETUP = 2'd0;
    localparam logic [1:0] FLD_START = 2'd1;
    localparam logic [1:0] FLD_LEN   = 2'd2;
    localparam logic [1:0] FLD_NSIG  = 2'd3;

endpackage

// File: rtl/cfgd_setup_table.sv
// Setup lookup table: stores one entry per scanned record, in scan order,
// and answers an associative lookup by setup number.
// Assumes: entries are written only during the table build; the lowest
// slot wins when several slots hold the same setup number.
module cfgd_setup_table #(
    parameter int NUM_SETUPS = 8,
    parameter int SETUP_W    = 8,
    parameter int ADDR_W     = 10,
    parameter int LEN_W      = 5,
    parameter int SIG_CNT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SETUP_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0]    wr_start,
    input  logic [LEN_W-1:0]     wr_len,
    input  logic [SIG_CNT_W-1:0] wr_nsig,
    input  logic [ADDR_W-1:0]    wr_sigbase,
    input  logic [SETUP_W-1:0]   look_id,
    output logic                 hit,
    output logic [ADDR_W-1:0]    hit_start,
    output logic [LEN_W-1:0]     hit_len,
    output logic [SIG_CNT_W-1:0] hit_nsig,
    output logic [ADDR_W-1:0]    hit_sigbase
);
    localparam int CNT_W = $clog2(NUM_SETUPS + 1);

    logic [CNT_W-1:0]     fill_q;
    logic [NUM_SETUPS-1:0] vld_q;
    logic [SETUP_W-1:0]   id_q      [NUM_SETUPS];
    logic [ADDR_W-1:0]    start_q   [NUM_SETUPS];
    logic [LEN_W-1:0]     len_q     [NUM_SETUPS];
    logic [SIG_CNT_W-1:0] nsig_q    [NUM_SETUPS];
    logic [ADDR_W-1:0]    sigbase_q [NUM_SETUPS];

    logic room;
    assign room = (fill_q < CNT_W'(NUM_SETUPS));

    // Append a new entry in the next free slot; drop it when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            vld_q  <= '0;
        end else if (wr_en && room) begin
            fill_q <= fill_q + CNT_W'(1);
            for (int i = 0; i < NUM_SETUPS; i++) begin
                if (fill_q == CNT_W'(i)) begin
                    vld_q[i]     <= 1'b1;
                    id_q[i]      <= wr_id;
                    start_q[i]   <= wr_start;
                    len_q[i]     <= wr_len;
                    nsig_q[i]    <= wr_nsig;
                    sigbase_q[i] <= wr_sigbase;
                end
            end
        end
    end

    // Associative lookup, lowest matching slot has priority.
    always_comb begin
        hit         = 1'b0;
        hit_start   = '0;
        hit_len     = '0;
        hit_nsig    = '0;
        hit_sigbase = '0;
        for (int i = NUM_SETUPS - 1; i >= 0; i--) begin
            if (vld_q[i] && (id_q[i] == look_id)) begin
                hit         = 1'b1;
                hit_start   = start_q[i];
                hit_len     = len_q[i];
                hit_nsig    = nsig_q[i];
                hit_sigbase = sigbase_q[i];
            end
        end
    end

    // R11: the fill count never passes the slot count.
    p_fill_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(NUM_SETUPS));

    // R11: a write into a full table leaves the fill count unchanged.
    p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !room) |=> $stable(fill_q));

endmodule

// File: rtl/cfgd_pe_select.sv
// Per-element write enable decode: an element at column x, row y is
// selected when its row bit and its column bit are both set.
// Assumes: masks are held stable while bus words are valid.
module cfgd_pe_select #(
    parameter int PE_ROWS = 4,
    parameter int PE_COLS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic [PE_ROWS-1:0]         row_mask,
    input  logic [PE_COLS-1:0]         col_mask,
    output logic [PE_ROWS*PE_COLS-1:0] pe_wr_en
);
    // One AND term per element of the array.
    for (genvar r = 0; r < PE_ROWS; r++) begin : g_row
        for (genvar c = 0; c < PE_COLS; c++) begin : g_col
            assign pe_wr_en[r*PE_COLS + c] = bus_valid & row_mask[r] & col_mask[c];
        end
    end

    // R5: no loader writes while the bus is idle.
    p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> ($countones(pe_wr_en) == 0));

endmodule

// File: rtl/cfgd_sequencer.sv
// Control sequencer: builds the setup table after reset, then serves
// requests by reading signatures and streaming code over the bus.
// Assumes: memory returns data one cycle after mem_rd_en; metadata is
// well formed; ADDR_W >= LEN_W.
module cfgd_sequencer
    import cfgd_pkg::*;
#(
    parameter int DATA_W       = 64,
    parameter int ADDR_W       = 10,
    parameter int SETUP_W      = 8,
    parameter int IMEM_DEPTH   = 16,
    parameter int SIG_CNT_W    = 4,
    parameter int PE_ROWS      = 4,
    parameter int PE_COLS      = 4,
    parameter int COL_MASK_LSB = 16,
    parameter int META_BASE    = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic                            mem_rd_en,
    output logic [ADDR_W-1:0]               mem_rd_addr,
    input  logic [DATA_W-1:0]               mem_rd_data,
    input  logic                            req_valid,
    output logic                            req_ready,
    output logic                            req_err,
    input  logic                            tbl_hit,
    input  logic [ADDR_W-1:0]               tbl_start,
    input  logic [$clog2(IMEM_DEPTH+1)-1:0] tbl_len,
    input  logic [SIG_CNT_W-1:0]            tbl_nsig,
    input  logic [ADDR_W-1:0]               tbl_sigbase,
    output logic                            tbl_wr_en,
    output logic [SETUP_W-1:0]              tbl_wr_id,
    output logic [ADDR_W-1:0]               tbl_wr_start,
    output logic [$clog2(IMEM_DEPTH+1)-1:0] tbl_wr_len,
    output logic [SIG_CNT_W-1:0]            tbl_wr_nsig,
    output logic [ADDR_W-1:0]               tbl_wr_sigbase,
    output logic                            bus_valid,
    output logic [$clog2(IMEM_DEPTH)-1:0]   bus_idx,
    output logic [DATA_W-1:0]               bus_data,
    output logic [PE_ROWS-1:0]              row_mask,
    output logic [PE_COLS-1:0]              col_mask,
    output logic                            cfg_done
);
    localparam int IDX_W = $clog2(IMEM_DEPTH);
    localparam int LEN_W = $clog2(IMEM_DEPTH + 1);

    seq_state_e            state_q;
    logic [ADDR_W-1:0]     ptr_q;
    logic [ADDR_W-1:0]     rec_left_q;
    logic [1:0]            fld_q;
    logic [SETUP_W-1:0]    cur_id_q;
    logic [ADDR_W-1:0]     cur_start_q;
    logic [LEN_W-1:0]      cur_len_q;
    logic [SIG_CNT_W-1:0]  cur_nsig_q;
    logic [ADDR_W-1:0]     cur_sigbase_q;
    logic [SIG_CNT_W-1:0]  sig_i_q;
    logic [LEN_W-1:0]      word_i_q;
    logic                  rd_vld_q;
    logic [IDX_W-1:0]      rd_idx_q;
    logic                  bus_valid_q;
    logic [IDX_W-1:0]      bus_idx_q;
    logic [DATA_W-1:0]     bus_data_q;
    logic [PE_ROWS-1:0]    row_mask_q;
    logic [PE_COLS-1:0]    col_mask_q;
    logic                  err_q;
    logic                  done_q;

    logic                  accept;
    logic [ADDR_W-1:0]     raw_len;
    logic [SIG_CNT_W-1:0]  raw_nsig;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign raw_len   = mem_rd_data[ADDR_W-1:0];
    assign raw_nsig  = mem_rd_data[SIG_CNT_W-1:0];

    // Memory read port: address chosen by the current phase.
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        case (state_q)
            ST_HDR: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = ADDR_W'(META_BASE);
            end
            ST_FLD: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = ptr_q;
            end
            ST_SIG: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = cur_sigbase_q + ADDR_W'(sig_i_q);
            end
            ST_STR: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = cur_start_q + ADDR_W'(word_i_q);
            end
            default: ;
        endcase
    end

    // Table write: the record is complete when its signature count arrives.
    assign tbl_wr_en      = (state_q == ST_FLD_W) && (fld_q == FLD_NSIG);
    assign tbl_wr_id      = cur_id_q;
    assign tbl_wr_start   = cur_start_q;
    assign tbl_wr_len     = cur_len_q;
    assign tbl_wr_nsig    = raw_nsig;
    assign tbl_wr_sigbase = ptr_q + ADDR_W'(1);

    // Phase sequencing, record capture and read pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_HDR;
            ptr_q         <= '0;
            rec_left_q    <= '0;
            fld_q         <= FLD_SETUP;
            cur_id_q      <= '0;
            cur_start_q   <= '0;
            cur_len_q     <= '0;
            cur_nsig_q    <= '0;
            cur_sigbase_q <= '0;
            sig_i_q       <= '0;
            word_i_q      <= '0;
            rd_vld_q      <= 1'b0;
            rd_idx_q      <= '0;
            bus_valid_q   <= 1'b0;
            bus_idx_q     <= '0;
            bus_data_q    <= '0;
            row_mask_q    <= '0;
            col_mask_q    <= '0;
            err_q         <= 1'b0;
            done_q        <= 1'b0;
        end else begin
            err_q       <= 1'b0;
            done_q      <= 1'b0;
            rd_vld_q    <= 1'b0;
            bus_valid_q <= rd_vld_q;
            if (rd_vld_q) begin
                bus_data_q <= mem_rd_data;
                bus_idx_q  <= rd_idx_q;
            end
            case (state_q)
                ST_HDR: state_q <= ST_HDR_W;
                ST_HDR_W: begin
                    rec_left_q <= raw_len;
                    ptr_q      <= ADDR_W'(META_BASE) + ADDR_W'(1);
                    fld_q      <= FLD_SETUP;
                    state_q    <= (raw_len == '0) ? ST_IDLE : ST_FLD;
                end
                ST_FLD: state_q <= ST_FLD_W;
                ST_FLD_W: begin
                    case (fld_q)
                        FLD_SETUP: cur_id_q    <= mem_rd_data[SETUP_W-1:0];
                        FLD_START: cur_start_q <= raw_len;
                        FLD_LEN: begin
                            if (raw_len > ADDR_W'(IMEM_DEPTH))
                                cur_len_q <= LEN_W'(IMEM_DEPTH);
                            else
                                cur_len_q <= raw_len[LEN_W-1:0];
                        end
                        default: ;
                    endcase
                    if (fld_q == FLD_NSIG) begin
                        ptr_q      <= ptr_q + ADDR_W'(1) + ADDR_W'(raw_nsig);
                        rec_left_q <= rec_left_q - ADDR_W'(1);
                        fld_q      <= FLD_SETUP;
                        state_q    <= (rec_left_q == ADDR_W'(1)) ? ST_IDLE : ST_FLD;
                    end else begin
                        ptr_q   <= ptr_q + ADDR_W'(1);
                        fld_q   <= fld_q + 2'd1;
                        state_q <= ST_FLD;
                    end
                end
                ST_IDLE: begin
                    if (accept) begin
                        if (!tbl_hit) begin
                            err_q <= 1'b1;
                        end else begin
                            cur_start_q   <= tbl_start;
                            cur_len_q     <= tbl_len;
                            cur_nsig_q    <= tbl_nsig;
                            cur_sigbase_q <= tbl_sigbase;
                            sig_i_q       <= '0;
                            if (tbl_nsig == '0) done_q  <= 1'b1;
                            else                state_q <= ST_SIG;
                        end
                    end
                end
                ST_SIG: state_q <= ST_SIG_W;
                ST_SIG_W: begin
                    row_mask_q <= mem_rd_data[PE_ROWS-1:0];
                    col_mask_q <= mem_rd_data[COL_MASK_LSB +: PE_COLS];
                    word_i_q   <= '0;
                    state_q    <= (cur_len_q == '0) ? ST_DRAIN : ST_STR;
                end
                ST_STR: begin
                    rd_vld_q <= 1'b1;
                    rd_idx_q <= word_i_q[IDX_W-1:0];
                    word_i_q <= word_i_q + LEN_W'(1);
                    if ((word_i_q + LEN_W'(1)) == cur_len_q) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!rd_vld_q) begin
                        if ((sig_i_q + SIG_CNT_W'(1)) == cur_nsig_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            sig_i_q <= sig_i_q + SIG_CNT_W'(1);
                            state_q <= ST_SIG;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_valid = bus_valid_q;
    assign bus_idx   = bus_idx_q;
    assign bus_data  = bus_data_q;
    assign row_mask  = row_mask_q;
    assign col_mask  = col_mask_q;
    assign req_err   = err_q;
    assign cfg_done  = done_q;

    // R12: while requests are taken, no code word is on the bus.
    p_ready_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_valid);

    // R6: each signature pass begins at instruction index zero.
    p_idx_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> (bus_idx == '0));

    // R6: back-to-back bus words carry consecutive indices.
    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && $past(bus_valid)) |-> (bus_idx == $past(bus_idx) + IDX_W'(1)));

    // R7: an error pulse is followed by no bus word.
    p_err_no_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !bus_valid);

    // R7: error and done never coincide.
    p_err_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !cfg_done);

    // R8: done is raised only once the bus has gone quiet.
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !bus_valid);

endmodule

// File: rtl/cfgd_dispatcher.sv
// Top of the configuration dispatcher: sequencer, setup table and
// per-element select decode.
// Assumes: one-cycle memory read latency; synchronous active-low reset.
module cfgd_dispatcher #(
    parameter int DATA_W       = 64,
    parameter int ADDR_W       = 10,
    parameter int SETUP_W      = 8,
    parameter int NUM_SETUPS   = 8,
    parameter int IMEM_DEPTH   = 16,
    parameter int SIG_CNT_W    = 4,
    parameter int PE_ROWS      = 4,
    parameter int PE_COLS      = 4,
    parameter int COL_MASK_LSB = 16,
    parameter int META_BASE    = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          mem_rd_en,
    output logic [ADDR_W-1:0]             mem_rd_addr,
    input  logic [DATA_W-1:0]             mem_rd_data,
    input  logic                          req_valid,
    input  logic [SETUP_W-1:0]            req_setup,
    output logic                          req_ready,
    output logic                          req_err,
    output logic                          cfg_bus_valid,
    output logic [$clog2(IMEM_DEPTH)-1:0] cfg_bus_idx,
    output logic [DATA_W-1:0]             cfg_bus_data,
    output logic [PE_ROWS-1:0]            cfg_bus_row_mask,
    output logic [PE_COLS-1:0]            cfg_bus_col_mask,
    output logic [PE_ROWS*PE_COLS-1:0]    pe_wr_en,
    output logic                          cfg_done
);
    localparam int LEN_W = $clog2(IMEM_DEPTH + 1);

    logic                 tbl_hit;
    logic [ADDR_W-1:0]    tbl_start;
    logic [LEN_W-1:0]     tbl_len;
    logic [SIG_CNT_W-1:0] tbl_nsig;
    logic [ADDR_W-1:0]    tbl_sigbase;
    logic                 tbl_wr_en;
    logic [SETUP_W-1:0]   tbl_wr_id;
    logic [ADDR_W-1:0]    tbl_wr_start;
    logic [LEN_W-1:0]     tbl_wr_len;
    logic [SIG_CNT_W-1:0] tbl_wr_nsig;
    logic [ADDR_W-1:0]    tbl_wr_sigbase;

    cfgd_sequencer #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETUP_W(SETUP_W),
        .IMEM_DEPTH(IMEM_DEPTH), .SIG_CNT_W(SIG_CNT_W),
        .PE_ROWS(PE_ROWS), .PE_COLS(PE_COLS),
        .COL_MASK_LSB(COL_MASK_LSB), .META_BASE(META_BASE)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_err(req_err),
        .tbl_hit(tbl_hit), .tbl_start(tbl_start), .tbl_len(tbl_len),
        .tbl_nsig(tbl_nsig), .tbl_sigbase(tbl_sigbase),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_id(tbl_wr_id), .tbl_wr_start(tbl_wr_start),
        .tbl_wr_len(tbl_wr_len), .tbl_wr_nsig(tbl_wr_nsig), .tbl_wr_sigbase(tbl_wr_sigbase),
        .bus_valid(cfg_bus_valid), .bus_idx(cfg_bus_idx), .bus_data(cfg_bus_data),
        .row_mask(cfg_bus_row_mask), .col_mask(cfg_bus_col_mask),
        .cfg_done(cfg_done)
    );

    cfgd_setup_table #(
        .NUM_SETUPS(NUM_SETUPS), .SETUP_W(SETUP_W), .ADDR_W(ADDR_W),
        .LEN_W(LEN_W), .SIG_CNT_W(SIG_CNT_W)
    ) i_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_id(tbl_wr_id), .wr_start(tbl_wr_start),
        .wr_len(tbl_wr_len), .wr_nsig(tbl_wr_nsig), .wr_sigbase(tbl_wr_sigbase),
        .look_id(req_setup),
        .hit(tbl_hit), .hit_start(tbl_start), .hit_len(tbl_len),
        .hit_nsig(tbl_nsig), .hit_sigbase(tbl_sigbase)
    );

    cfgd_pe_select #(
        .PE_ROWS(PE_ROWS), .PE_COLS(PE_COLS)
    ) i_sel (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(cfg_bus_valid),
        .row_mask(cfg_bus_row_mask), .col_mask(cfg_bus_col_mask),
        .pe_wr_en(pe_wr_en)
    );

    // R1: no memory read is issued while requests are being taken.
    p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);

endmodule

// File: tb/test_cfgd_dispatcher.sv
`timescale 1ns/1ps
module test_cfgd_dispatcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd_en;
    logic [9:0]  mem_rd_addr;
    logic [63:0] mem_rd_data = '0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_setup = '0;
    logic        req_ready, req_err, cfg_bus_valid, cfg_done;
    logic [3:0]  cfg_bus_idx, cfg_bus_row_mask, cfg_bus_col_mask;
    logic [63:0] cfg_bus_data;
    logic [15:0] pe_wr_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mem [0:255];

    always #4 clk = ~clk;

    // Memory model with one-cycle read latency.
    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

    cfgd_dispatcher #(.NUM_SETUPS(5)) i_cfgd_dispatcher (
        .clk(clk), .rst_n(rst_n),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .req_valid(req_valid), .req_setup(req_setup), .req_ready(req_ready), .req_err(req_err),
        .cfg_bus_valid(cfg_bus_valid), .cfg_bus_idx(cfg_bus_idx), .cfg_bus_data(cfg_bus_data),
        .cfg_bus_row_mask(cfg_bus_row_mask), .cfg_bus_col_mask(cfg_bus_col_mask),
        .pe_wr_en(pe_wr_en), .cfg_done(cfg_done)
    );

    typedef struct packed {
        logic [7:0]  id;
        logic        err;
        logic [15:0] start;
        logic [7:0]  len;    // effective length after truncation
        logic [3:0]  nsig;
        logic [31:0] s0;
        logic [31:0] s1;
    } vec_t;

    // Request vectors and expected results.
    localparam vec_t VECS [6] = '{
        '{8'd3,  1'b0, 16'd100, 8'd5,  4'd1, 32'h0005_0003, 32'h0},          // R3 R10: first record for 3
        '{8'd7,  1'b0, 16'd40,  8'd16, 4'd2, 32'h0008_0001, 32'h0003_000C},  // R4: two signature passes
        '{8'd9,  1'b0, 16'd150, 8'd16, 4'd1, 32'h000F_000F, 32'h0},          // R9: 20 cut to 16
        '{8'd12, 1'b0, 16'd60,  8'd3,  4'd0, 32'h0,         32'h0},          // R13: no signatures
        '{8'd5,  1'b1, 16'd0,   8'd0,  4'd0, 32'h0,         32'h0},          // R11: beyond capacity
        '{8'd4,  1'b1, 16'd0,   8'd0,  4'd0, 32'h0,         32'h0}           // R7: never listed
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pe(input logic [31:0] s);
        logic [15:0] e;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                e[r*4 + c] = s[r] & s[16 + c];
        return e;
    endfunction

    int wp;
    task automatic add_rec(input int id, input int st, input int ln, input int ns,
                           input logic [31:0] s0, input logic [31:0] s1);
        mem[wp]     = 64'(id);
        mem[wp + 1] = 64'(st);
        mem[wp + 2] = 64'(ln);
        mem[wp + 3] = 64'(ns);
        if (ns > 0) mem[wp + 4] = 64'(s0);
        if (ns > 1) mem[wp + 5] = 64'(s1);
        wp = wp + 4 + ns;
    endtask

    task automatic run_vec(input vec_t v);
        int words = 0, bad_idx = 0, bad_data = 0, bad_pe = 0;
        int last_bus = -1, done_cyc = -1, err_cyc = -1, err_cnt = 0, stop = 100000;
        int li;
        logic [31:0] sg;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_setup = v.id;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc <= 600 && cyc <= stop; cyc++) begin
            if (cfg_bus_valid) begin
                li = (v.len == 0) ? 0 : words % int'(v.len);
                sg = (v.len != 0 && words / int'(v.len) == 1) ? v.s1 : v.s0;
                if (cfg_bus_idx != 4'(li)) bad_idx++;
                if (cfg_bus_data != mem[8'(int'(v.start) + li)]) bad_data++;
                if (pe_wr_en != exp_pe(sg)) bad_pe++;
                words++;
                last_bus = cyc;
            end
            if (req_err) begin
                err_cnt++;
                if (err_cyc < 0) err_cyc = cyc;
            end
            if (cfg_done && done_cyc < 0) done_cyc = cyc;
            if ((done_cyc >= 0 || err_cyc >= 0) && stop == 100000) stop = cyc + 4;
            @(negedge clk);
        end
        if (v.err) begin
            chk(err_cyc == 1, "R7 error pulse one cycle after request", err_cyc, 1);
            chk(err_cnt == 1, "R7 error pulse width", err_cnt, 1);
            chk(words == 0 && done_cyc < 0, "R7/R11 no transfer on unknown setup", words, 0);
        end else begin
            chk(err_cyc < 0, "R7 no error for listed setup", err_cyc, -1);
            chk(words == int'(v.nsig) * int'(v.len), "R4/R9 word count",
                words, int'(v.nsig) * int'(v.len));
            chk(bad_data == 0, "R2/R3/R10 code data from table address", bad_data, 0);
            chk(bad_idx == 0, "R6 index sequence", bad_idx, 0);
            chk(bad_pe == 0, "R5 element selection", bad_pe, 0);
            if (words > 0)
                chk(done_cyc == last_bus + 1, "R8 done cycle", done_cyc, last_bus + 1);
            else
                chk(done_cyc == 1, "R13 done at once with no signatures", done_cyc, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ready_cyc = 0;
        int stray = 0;
        for (int a = 0; a < 256; a++) mem[a] = {16'hC0DE, 8'h5A, 8'(a), 32'(a * 7 + 1)};
        // R2: record layout; header word gives six records.
        mem[0] = 64'd6;
        wp = 1;
        add_rec(3,  100, 5,  1, 32'h0005_0003, 32'h0);
        add_rec(7,  40,  16, 2, 32'h0008_0001, 32'h0003_000C);
        add_rec(3,  200, 2,  1, 32'h000F_000F, 32'h0);
        add_rec(9,  150, 20, 1, 32'h000F_000F, 32'h0);
        add_rec(12, 60,  3,  0, 32'h0,         32'h0);
        add_rec(5,  70,  1,  1, 32'h0001_0001, 32'h0);

        // Reset state.
        repeat (3) @(negedge clk);
        chk(!req_ready && !cfg_bus_valid && !cfg_done && !req_err,
            "R1 outputs quiet in reset", req_ready, 0);
        rst_n = 1'b1;

        // R1 R12: request held during table build is ignored.
        req_valid = 1'b1;
        req_setup = 8'd3;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_ready || cfg_bus_valid || req_err || cfg_done) stray++;
            ready_cyc++;
        end
        req_valid = 1'b0;
        while (!req_ready && ready_cyc < 500) begin
            @(negedge clk);
            if (cfg_bus_valid || req_err || cfg_done) stray++;
            ready_cyc++;
        end
        chk(stray == 0, "R12 request during build ignored", stray, 0);
        chk(ready_cyc >= 25 && ready_cyc < 500, "R1 ready only after full scan", ready_cyc, 50);

        foreach (VECS[k]) run_vec(VECS[k]);

        // R12: request raised during a transfer is dropped.
        begin
            int words = 0, errs = 0, dones = 0;
            while (!req_ready) @(negedge clk);
            req_valid = 1'b1;
            req_setup = 8'd9;
            @(negedge clk);
            req_setup = 8'd4;
            for (int i = 0; i < 120; i++) begin
                if (i == 6) req_valid = 1'b0;
                if (cfg_bus_valid) words++;
                if (req_err) errs++;
                if (cfg_done) dones++;
                @(negedge clk);
            end
            chk(errs == 0, "R12 busy request ignored", errs, 0);
            chk(words == 16 && dones == 1, "R12 transfer intact", words, 16);
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule